// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers interrupt requests from on-chip peripherals and from external request pins and turns them into the processor's two interrupt inputs. Every request source has its own enable bit, a three-bit priority level and an eight-bit vector. Among the sources that are both pending and enabled, the arbiter picks the highest level. When two or more share that level, the lowest source index wins. The standard interrupt output (active low) is driven whenever such a winner exists. A separate fast interrupt output (active low) follows one dedicated external pin only, and no source can reach it.

Software takes an interrupt by reading the vector register. This returns the winner's vector and pushes the winner's level and index onto a service stack. While the stack is not empty, only sources of a strictly higher level than the top entry can assert the standard output, so handlers nest by priority. Writing the end-of-service register pops the stack. Each external request pin is synchronised and can be set to level mode or edge mode. In edge mode a rising edge sets a pending latch, which stays set until service entry of that source.

Register map (5-bit address, 32-bit data): 0x00 enable-set, 0x01 enable-clear, 0x02 enable read, 0x03 raw pending read, 0x04 vector read, 0x05 in-service identity read, 0x06 end-of-service write, 0x10+i configuration of source i. Internal sources take indices 0 to NUM_INT-1, and the external pins follow them.

Top module: `vic8_ctrl`

## Requirements
- R1: After reset, irq_n_o and fiq_n_o are 1, all enable bits are 0, the service stack is empty, and every configuration register reads 0.
- R2: Writing to 0x00 sets the enable bits where the data holds a 1. Writing to 0x01 clears the enable bits where the data holds a 1. Zero bits have no effect in either case. Address 0x02 returns the enable bits in bits [NSRC-1:0].
- R3: A source whose enable bit is 0 never asserts irq_n_o. Its raw request still shows in bit i of the pending register at 0x03.
- R4: irq_n_o goes low when any eligible source is pending and enabled. A read of 0x04 returns the vector (bits [7:0]) of the eligible source with the numerically largest level, where level 7 is the most urgent.
- R5: When several eligible sources share the highest level, the one with the lowest index wins.
- R6: A read of 0x04 that finds a winner pushes its level and index. From then on only sources whose level is strictly above the top entry are eligible. Reading 0x05 returns the top index in bits [2:0] and an active flag in bit 8.
- R7: Any write to 0x06 pops one stack entry and restores the previous threshold. With the stack empty it has no effect.
- R8: A read of 0x04 with no eligible source returns the spurious vector (default 0xFF) and leaves the stack unchanged.
- R9: fiq_n_o is low exactly when fiq_i was high three clock edges earlier. It is independent of every request source and every register.
- R10: An external source in edge mode latches pending on a rising edge of its pin. The latch stays pending after the pin falls and is cleared by the 0x04 read that selects that source.
- R11: An external source in level mode is pending exactly while its synchronised pin is high.
- R12: A write to 0x10+i stores the level in bits [2:0], the edge-mode flag in bit 4 and the vector in bits [15:8]. A read returns the same fields. The edge-mode flag of an internal source always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| int_src_i | input | NUM_INT | Internal peripheral requests, level, synchronous |
| ext_irq_i | input | NUM_EXT | External request pins, asynchronous |
| fiq_i | input | 1 | Dedicated fast-interrupt pin, asynchronous |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 5 | Register write address |
| wr_data_i | input | 32 | Register write data |
| rd_en_i | input | 1 | Register read strobe (side effect on 0x04) |
| rd_addr_i | input | 5 | Register read address |
| rd_data_o | output | 32 | Combinational read data for rd_addr_i |
| irq_n_o | output | 1 | Standard interrupt request, active low |
| fiq_n_o | output | 1 | Fast interrupt request, active low |

## Verification
The assertions take for granted that a vector read and an end-of-service write never fall in the same cycle. They also assume that external pins hold each value for at least one clock, so that the synchroniser sees every edge. The stimulus keeps to this because each register access runs from one falling edge to the next, with only one access in flight at a time. Pin changes are held for four clocks before the next operation.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] A_EN_SET  = 5'h00;
  localparam logic [ADDR_W-1:0] A_EN_CLR  = 5'h01;
  localparam logic [ADDR_W-1:0] A_EN_RD   = 5'h02;
  localparam logic [ADDR_W-1:0] A_PENDING = 5'h03;
  localparam logic [ADDR_W-1:0] A_VECTOR  = 5'h04;
  localparam logic [ADDR_W-1:0] A_SVC_ID  = 5'h05;
  localparam logic [ADDR_W-1:0] A_EOI     = 5'h06;

  localparam int CFG_EDGE_BIT = 4;
  localparam int CFG_VEC_LSB  = 8;
  localparam int SVC_ACT_BIT  = 8;
endpackage

// File: rtl/vic_ext_front.sv
module vic_ext_front #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pin_i,
  input  logic [N-1:0] edge_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);

  for (genvar g = 0; g < N; g++) begin : g_ch
    logic s1_q, s2_q, s3_q;
    logic lat_q, lat_d;
    logic rise;

    assign rise  = s2_q & ~s3_q;

    always_comb begin
      if (edge_i[g]) lat_d = (lat_q & ~clr_i[g]) | rise;
      else           lat_d = 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q  <= 1'b0;
        s2_q  <= 1'b0;
        s3_q  <= 1'b0;
        lat_q <= 1'b0;
      end else begin
        s1_q  <= pin_i[g];
        s2_q  <= s1_q;
        s3_q  <= s2_q;
        lat_q <= lat_d;
      end
    end

    assign pend_o[g] = edge_i[g] ? lat_q : s2_q;

    // R10: a latched edge survives until its service entry clears it
    a_r10_latch_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (edge_i[g] && lat_q && !clr_i[g]) |=> lat_q);

    // R10: a synchronised rising edge in edge mode is always captured
    a_r10_edge_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (edge_i[g] && s2_q && !s3_q) |=> lat_q);

    // R11: level mode keeps no stale latch
    a_r11_no_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !edge_i[g] |=> !lat_q);
  end

endmodule

// File: rtl/vic_prio_arb.sv
module vic_prio_arb #(
  parameter int NSRC = 8,
  parameter int LW   = 3,
  localparam int IW  = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [NSRC-1:0]         req_i,
  input  logic [NSRC-1:0][LW-1:0] lvl_i,
  input  logic                    thr_en_i,
  input  logic [LW-1:0]           thr_i,
  output logic [NSRC-1:0]         elig_o,
  output logic                    win_valid_o,
  output logic [IW-1:0]           win_id_o,
  output logic [LW-1:0]           win_lvl_o
);

  always_comb begin
    for (int i = 0; i < NSRC; i++) begin
      elig_o[i] = req_i[i] && (!thr_en_i || (lvl_i[i] > thr_i));
    end
  end

  // Ascending scan with strict compare: ties keep the lowest index.
  always_comb begin
    win_valid_o = 1'b0;
    win_id_o    = '0;
    win_lvl_o   = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (elig_o[i] && (!win_valid_o || (lvl_i[i] > win_lvl_o))) begin
        win_valid_o = 1'b1;
        win_id_o    = IW'(i);
        win_lvl_o   = lvl_i[i];
      end
    end
  end

endmodule

// File: rtl/vic_svc_stack.sv
module vic_svc_stack #(
  parameter int DEPTH = 8,
  parameter int LW    = 3,
  parameter int IW    = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [LW-1:0] lvl_i,
  input  logic [IW-1:0] id_i,
  output logic          active_o,
  output logic [LW-1:0] top_lvl_o,
  output logic [IW-1:0] top_id_o
);

  localparam int CW = $clog2(DEPTH + 1);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          we;
  logic [PW-1:0] wptr;
  logic [PW-1:0] top_idx;
  logic [LW-1:0] lvl_mem [DEPTH];
  logic [IW-1:0] id_mem  [DEPTH];

  always_comb begin
    cnt_d = cnt_q;
    we    = 1'b0;
    wptr  = PW'(cnt_q);
    if (push_i && pop_i) begin
      we = 1'b1;
      if (cnt_q != '0) wptr = PW'(cnt_q - 1'b1);
      else             cnt_d = cnt_q + 1'b1;
    end else if (push_i && (cnt_q < DEPTH_C)) begin
      we    = 1'b1;
      cnt_d = cnt_q + 1'b1;
    end else if (pop_i && (cnt_q != '0)) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  always_ff @(posedge clk_i) begin
    if (we) begin
      lvl_mem[wptr] <= lvl_i;
      id_mem[wptr]  <= id_i;
    end
  end

  assign top_idx   = PW'(cnt_q - 1'b1);
  assign active_o  = (cnt_q != '0);
  assign top_lvl_o = active_o ? lvl_mem[top_idx] : '0;
  assign top_id_o  = active_o ? id_mem[top_idx]  : '0;

  // R6: strictly rising levels bound the depth to the level count
  a_r6_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i) |-> (cnt_q < DEPTH_C));

  // R6: a push enters at a level above the previous top
  a_r6_push_rises: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i && active_o) |-> (lvl_i > top_lvl_o));

  // R7: a pop on a non-empty stack removes exactly one entry
  a_r7_pop_dec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && active_o) |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R7: a pop on an empty stack leaves it empty
  a_r7_pop_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && !active_o) |=> !active_o);

endmodule

// File: rtl/vic8_ctrl.sv
module vic8_ctrl
  import vic_pkg::*;
#(
  parameter int                 NUM_INT  = 6,
  parameter int                 NUM_EXT  = 2,
  parameter int                 NUM_LVL  = 8,
  parameter int                 VEC_W    = 8,
  parameter logic [VEC_W-1:0]   SPUR_VEC = 8'hFF
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_INT-1:0]    int_src_i,
  input  logic [NUM_EXT-1:0]    ext_irq_i,
  input  logic                  fiq_i,
  input  logic                  wr_en_i,
  input  logic [ADDR_W-1:0]     wr_addr_i,
  input  logic [DATA_W-1:0]     wr_data_i,
  input  logic                  rd_en_i,
  input  logic [ADDR_W-1:0]     rd_addr_i,
  output logic [DATA_W-1:0]     rd_data_o,
  output logic                  irq_n_o,
  output logic                  fiq_n_o
);

  localparam int NSRC = NUM_INT + NUM_EXT;
  localparam int IW   = (NSRC > 1) ? $clog2(NSRC) : 1;
  localparam int LW   = (NUM_LVL > 1) ? $clog2(NUM_LVL) : 1;
  localparam logic [ADDR_W-2:0] NSRC_A = (ADDR_W-1)'(NSRC);

  // ---------------- reset synchroniser ----------------
  logic [1:0] rst_pipe;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  // ---------------- configuration state ----------------
  logic [NSRC-1:0]            en_q, en_d;
  logic [NSRC-1:0][LW-1:0]    lvl_q, lvl_d;
  logic [NSRC-1:0][VEC_W-1:0] vec_q, vec_d;
  logic [NUM_EXT-1:0]         edge_q, edge_d;
  logic                       wr_cfg, en_we;
  logic [IW-1:0]              wr_idx;

  assign wr_cfg = wr_en_i && wr_addr_i[ADDR_W-1] && (wr_addr_i[ADDR_W-2:0] < NSRC_A);
  assign wr_idx = wr_addr_i[IW-1:0];
  assign en_we  = wr_en_i && ((wr_addr_i == A_EN_SET) || (wr_addr_i == A_EN_CLR));

  always_comb begin
    en_d = en_q;
    if (wr_en_i && (wr_addr_i == A_EN_SET))      en_d = en_q | wr_data_i[NSRC-1:0];
    else if (wr_en_i && (wr_addr_i == A_EN_CLR)) en_d = en_q & ~wr_data_i[NSRC-1:0];
  end

  always_comb begin
    lvl_d  = lvl_q;
    vec_d  = vec_q;
    edge_d = edge_q;
    if (wr_cfg) begin
      lvl_d[wr_idx] = wr_data_i[LW-1:0];
      vec_d[wr_idx] = wr_data_i[CFG_VEC_LSB +: VEC_W];
    end
    for (int j = 0; j < NUM_EXT; j++) begin
      if (wr_cfg && (wr_idx == IW'(NUM_INT + j))) edge_d[j] = wr_data_i[CFG_EDGE_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      en_q   <= '0;
      lvl_q  <= '0;
      vec_q  <= '0;
      edge_q <= '0;
    end else begin
      if (en_we) en_q <= en_d;
      if (wr_cfg) begin
        lvl_q  <= lvl_d;
        vec_q  <= vec_d;
        edge_q <= edge_d;
      end
    end
  end

  // ---------------- request front end ----------------
  logic [NUM_EXT-1:0] ext_pend, ext_clr;
  logic [NSRC-1:0]    pend_all, req, elig;

  vic_ext_front #(.N(NUM_EXT)) u_front (
    .clk_i  (clk),
    .rst_ni (rst_n_s),
    .pin_i  (ext_irq_i),
    .edge_i (edge_q),
    .clr_i  (ext_clr),
    .pend_o (ext_pend)
  );

  assign pend_all = {ext_pend, int_src_i};
  assign req      = pend_all & en_q;

  // ---------------- arbitration and service stack ----------------
  logic          win_valid, svc_active, push, pop;
  logic [IW-1:0] win_id, top_id;
  logic [LW-1:0] win_lvl, top_lvl;

  vic_prio_arb #(.NSRC(NSRC), .LW(LW)) u_arb (
    .req_i       (req),
    .lvl_i       (lvl_q),
    .thr_en_i    (svc_active),
    .thr_i       (top_lvl),
    .elig_o      (elig),
    .win_valid_o (win_valid),
    .win_id_o    (win_id),
    .win_lvl_o   (win_lvl)
  );

  assign push = rd_en_i && (rd_addr_i == A_VECTOR) && win_valid;
  assign pop  = wr_en_i && (wr_addr_i == A_EOI);

  vic_svc_stack #(.DEPTH(NUM_LVL), .LW(LW), .IW(IW)) u_stack (
    .clk_i     (clk),
    .rst_ni    (rst_n_s),
    .push_i    (push),
    .pop_i     (pop),
    .lvl_i     (win_lvl),
    .id_i      (win_id),
    .active_o  (svc_active),
    .top_lvl_o (top_lvl),
    .top_id_o  (top_id)
  );

  for (genvar j = 0; j < NUM_EXT; j++) begin : g_clr
    assign ext_clr[j] = push && (win_id == IW'(NUM_INT + j));
  end

  // ---------------- read mux ----------------
  logic          rd_cfg;
  logic [IW-1:0] rd_idx;
  logic [NSRC-1:0] edge_full;

  assign rd_cfg    = rd_addr_i[ADDR_W-1] && (rd_addr_i[ADDR_W-2:0] < NSRC_A);
  assign rd_idx    = rd_addr_i[IW-1:0];
  assign edge_full = {edge_q, {NUM_INT{1'b0}}};

  always_comb begin
    rd_data_o = '0;
    if (rd_cfg) begin
      rd_data_o[LW-1:0]                = lvl_q[rd_idx];
      rd_data_o[CFG_EDGE_BIT]          = edge_full[rd_idx];
      rd_data_o[CFG_VEC_LSB +: VEC_W]  = vec_q[rd_idx];
    end else begin
      case (rd_addr_i)
        A_EN_RD:   rd_data_o[NSRC-1:0] = en_q;
        A_PENDING: rd_data_o[NSRC-1:0] = pend_all;
        A_VECTOR:  rd_data_o[VEC_W-1:0] = win_valid ? vec_q[win_id] : SPUR_VEC;
        A_SVC_ID: begin
          rd_data_o[IW-1:0]        = top_id;
          rd_data_o[SVC_ACT_BIT]   = svc_active;
        end
        default:   rd_data_o = '0;
      endcase
    end
  end

  // ---------------- output stage ----------------
  logic irq_n_q, irq_n_d;
  logic fiq_s1_q, fiq_s2_q, fiq_n_q;

  assign irq_n_d = ~win_valid;

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      irq_n_q  <= 1'b1;
      fiq_s1_q <= 1'b0;
      fiq_s2_q <= 1'b0;
      fiq_n_q  <= 1'b1;
    end else begin
      irq_n_q  <= irq_n_d;
      fiq_s1_q <= fiq_i;
      fiq_s2_q <= fiq_s1_q;
      fiq_n_q  <= ~fiq_s2_q;
    end
  end

  assign irq_n_o = irq_n_q;
  assign fiq_n_o = fiq_n_q;

  // ---------------- assertions ----------------
  // R3: a selected source is always both enabled and requesting
  a_r3_win_enabled: assert property (@(posedge clk) disable iff (!rst_n_s)
    win_valid |-> (en_q[win_id] && pend_all[win_id]));

  // R4: the winner comes from the eligible set, and an empty set yields none
  a_r4_win_eligible: assert property (@(posedge clk) disable iff (!rst_n_s)
    win_valid |-> elig[win_id]);
  a_r4_none_idle: assert property (@(posedge clk) disable iff (!rst_n_s)
    !win_valid |-> (elig == '0));

  // R6: during service only strictly higher levels win
  a_r6_above_thr: assert property (@(posedge clk) disable iff (!rst_n_s)
    (win_valid && svc_active) |-> (win_lvl > top_lvl));

  // R6: a successful vector read records the winner on top
  a_r6_push_id: assert property (@(posedge clk) disable iff (!rst_n_s)
    (push && !pop) |=> (svc_active && (top_id == $past(win_id))));

  // R8: a spurious vector read leaves the service state alone
  a_r8_spur_stable: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rd_en_i && (rd_addr_i == A_VECTOR) && !win_valid && !pop)
      |=> ($stable(svc_active) && $stable(top_id)));

  // R9: the fast output only follows the fast pin
  a_r9_fiq_src: assert property (@(posedge clk) disable iff (!rst_n_s)
    !fiq_n_o |-> $past(fiq_i, 3));

endmodule

// File: tb/vic8_ctrl_tb_top.sv
`timescale 1ns/1ps
module vic8_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [5:0]  int_src;
  logic [1:0]  ext_irq;
  logic        fiq;
  logic        wr_en, rd_en;
  logic [4:0]  wr_addr, rd_addr;
  logic [31:0] wr_data, rd_data;
  logic        irq_n, fiq_n;

  always #2 clk = ~clk;

  vic8_ctrl dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .int_src_i (int_src),
    .ext_irq_i (ext_irq),
    .fiq_i     (fiq),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .rd_en_i   (rd_en),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data),
    .irq_n_o   (irq_n),
    .fiq_n_o   (fiq_n)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // reference model state
  bit [7:0] m_en;
  int       m_lvl [8];
  int       m_vec [8];
  bit       m_edge [2];
  bit       m_ep [2];
  int       m_sl [8];
  int       m_si [8];
  int       m_sp;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic bit m_pend(int i);
    if (i < 6) return int_src[i];
    if (m_edge[i-6]) return m_ep[i-6];
    return ext_irq[i-6];
  endfunction

  function automatic int m_win();
    int best = -1;
    for (int i = 0; i < 8; i++) begin
      if (m_en[i] && m_pend(i) && (m_sp == 0 || m_lvl[i] > m_sl[m_sp-1]))
        if (best < 0 || m_lvl[i] > m_lvl[best]) best = i;
    end
    return best;
  endfunction

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic bus_wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    #1 d = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic cfg(int i, int lvl, bit edg, int vec);
    bus_wr(5'(16 + i), {16'h0, 8'(vec), 3'b0, edg, 1'b0, 3'(lvl)});
    m_lvl[i] = lvl;
    m_vec[i] = vec;
    if (i >= 6) begin
      m_edge[i-6] = edg;
      if (!edg) m_ep[i-6] = 1'b0;
    end
  endtask

  task automatic en_set(bit [7:0] m);
    bus_wr(5'h00, {24'h0, m});
    m_en |= m;
  endtask

  task automatic en_clr(bit [7:0] m);
    bus_wr(5'h01, {24'h0, m});
    m_en &= ~m;
  endtask

  task automatic vec_rd(output logic [31:0] v, output logic [31:0] e);
    int w = m_win();
    bus_rd(5'h04, v);
    if (w >= 0) begin
      e = 32'(m_vec[w]);
      m_sl[m_sp] = m_lvl[w];
      m_si[m_sp] = w;
      m_sp++;
      if (w >= 6 && m_edge[w-6]) m_ep[w-6] = 1'b0;
    end else begin
      e = 32'h0000_00FF;
    end
  endtask

  task automatic eoi();
    bus_wr(5'h06, 32'h0);
    if (m_sp > 0) m_sp--;
  endtask

  task automatic set_int(logic [5:0] v);
    @(negedge clk);
    int_src = v;
    settle();
  endtask

  task automatic set_ext(int j, bit v);
    @(negedge clk);
    if (v && !ext_irq[j] && m_edge[j]) m_ep[j] = 1'b1;
    ext_irq[j] = v;
    settle();
  endtask

  task automatic chk_irq(string req);
    chk(req, {31'h0, irq_n}, (m_win() < 0) ? 32'h1 : 32'h0);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, e;
    int op;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; int_src = '0; ext_irq = '0; fiq = 1'b0;
    wr_en = 1'b0; rd_en = 1'b0; wr_addr = '0; rd_addr = '0; wr_data = '0;
    m_en = '0; m_sp = 0;
    for (int i = 0; i < 8; i++) begin m_lvl[i] = 0; m_vec[i] = 0; end
    for (int j = 0; j < 2; j++) begin m_edge[j] = 0; m_ep[j] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();

    // R1 reset state
    chk("R1 irq_n", {31'h0, irq_n}, 32'h1);
    chk("R1 fiq_n", {31'h0, fiq_n}, 32'h1);
    bus_rd(5'h02, v); chk("R1 enables", v, 32'h0);
    bus_rd(5'h05, v); chk("R1 stack idle", v, 32'h0);
    bus_rd(5'h13, v); chk("R1 cfg", v, 32'h0);

    // R12 configuration readback
    cfg(3, 5, 1'b1, 8'h5A);
    bus_rd(5'h13, v); chk("R12 internal cfg, edge reads 0", v, 32'h5A05);
    cfg(6, 2, 1'b1, 8'h66);
    bus_rd(5'h16, v); chk("R12 external cfg", v, 32'h6612);

    // R2 set/clear with zero bits ignored
    en_set(8'h09); bus_rd(5'h02, v); chk("R2 set", v, 32'h09);
    en_set(8'h00); bus_rd(5'h02, v); chk("R2 zero set", v, 32'h09);
    en_clr(8'h01); bus_rd(5'h02, v); chk("R2 clear", v, 32'h08);
    en_clr(8'h00); bus_rd(5'h02, v); chk("R2 zero clear", v, 32'h08);

    // R3 masked source
    set_int(6'h01);
    chk("R3 masked irq_n", {31'h0, irq_n}, 32'h1);
    bus_rd(5'h03, v); chk("R3 raw pending", v, 32'h01);

    // R4 priority
    cfg(1, 2, 1'b0, 8'h11);
    cfg(2, 6, 1'b0, 8'h22);
    cfg(4, 7, 1'b0, 8'h44);
    en_set(8'h16);
    set_int(6'h06);
    settle();
    chk("R4 irq asserted", {31'h0, irq_n}, 32'h0);
    vec_rd(v, e); chk("R4 highest level vector", v, 32'h22);
    bus_rd(5'h05, v); chk("R6 id of source 2", v, 32'h102);
    settle();
    chk("R6 lower level blocked", {31'h0, irq_n}, 32'h1);

    // R6 nesting by strictly higher level
    set_int(6'h16);
    chk("R6 higher level passes", {31'h0, irq_n}, 32'h0);
    vec_rd(v, e); chk("R6 nested vector", v, 32'h44);
    bus_rd(5'h05, v); chk("R6 nested id", v, 32'h104);

    // R7 pop restores
    eoi(); bus_rd(5'h05, v); chk("R7 pop to previous", v, 32'h102);
    eoi(); bus_rd(5'h05, v); chk("R7 pop to empty", v, 32'h0);
    eoi(); bus_rd(5'h05, v); chk("R7 pop on empty", v, 32'h0);
    settle();
    chk("R7 irq returns", {31'h0, irq_n}, 32'h0);

    // R5 tie: sources 1 and 2 at level 6
    set_int(6'h06);
    cfg(1, 6, 1'b0, 8'h11);
    vec_rd(v, e); chk("R5 lowest index wins tie", v, 32'h11);
    eoi();

    // R8 spurious read
    set_int(6'h00);
    vec_rd(v, e); chk("R8 spurious vector", v, 32'h0FF);
    bus_rd(5'h05, v); chk("R8 no push", v, 32'h0);

    // R9 fast interrupt path
    set_int(6'h3F);
    chk("R9 sources leave fiq", {31'h0, fiq_n}, 32'h1);
    @(negedge clk); fiq = 1'b1; settle();
    chk("R9 fiq asserted", {31'h0, fiq_n}, 32'h0);
    @(negedge clk); fiq = 1'b0; settle();
    chk("R9 fiq released", {31'h0, fiq_n}, 32'h1);
    set_int(6'h00);

    // R10 edge latch on source 6
    en_set(8'h40);
    set_ext(0, 1'b1);
    set_ext(0, 1'b0);
    chk("R10 latched irq", {31'h0, irq_n}, 32'h0);
    bus_rd(5'h03, v); chk("R10 pending held", v, 32'h40);
    vec_rd(v, e); chk("R10 vector", v, 32'h66);
    bus_rd(5'h03, v); chk("R10 cleared on entry", v, 32'h00);
    eoi();
    settle();
    chk("R10 no re-trigger", {31'h0, irq_n}, 32'h1);

    // R11 level mode on source 7
    cfg(7, 1, 1'b0, 8'h77);
    en_set(8'h80);
    set_ext(1, 1'b1);
    chk("R11 level high", {31'h0, irq_n}, 32'h0);
    bus_rd(5'h03, v); chk("R11 pending follows", v, 32'h80);
    set_ext(1, 1'b0);
    chk("R11 level low", {31'h0, irq_n}, 32'h1);

    // constrained random against the model
    for (int it = 0; it < 400; it++) begin
      op = int'($urandom % 7);
      case (op)
        0: set_int(6'($urandom));
        1: set_ext(int'($urandom % 2), 1'($urandom));
        2: cfg(int'($urandom % 8), int'($urandom % 8), 1'($urandom), int'($urandom % 256));
        3: en_set(8'($urandom));
        4: en_clr(8'($urandom & $urandom));
        5: begin vec_rd(v, e); chk("R4 R6 random vector", v, e); end
        default: eoi();
      endcase
      settle();
      chk_irq("R4 R6 R7 random irq_n");
      chk("R9 random fiq_n", {31'h0, fiq_n}, 32'h1);
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule